// File: doc/BRIEF.md
# DMA Line-Chunking Request Sequencer

This block takes one DMA transfer at a time, described by a start byte address, a byte count and a direction. It breaks the transfer into memory transactions that never cross a cache-line boundary and sends them one by one to a downstream memory port. A new chunk goes out only after the previous one has been answered: read chunks wait for a data response and write chunks wait for an acknowledgement. When the final chunk is answered, the block signals completion to the requester and becomes free for the next transfer.

Only the first chunk can start partway into a line. Every later chunk begins on a line boundary, and its size is the line size or whatever bytes remain, whichever is smaller. The block holds a local byte buffer. Before a write, the requester loads that buffer through a host byte port. After a read, the requester collects the result from the same port. The block gathers read bytes from the line positions it asked for, and it places write bytes at the matching line positions.

Top module: `dma_line_seq`

## Requirements
- R1: `reqReady` is 1 exactly when the block is idle. A valid request accepted on a clock edge makes `busy` 1 from the next cycle. `busy` then stays 1 until the cycle after the `done` pulse.
- R2: Operation code 0 is a load and code 1 is a store. Codes 2 to 7 raise `reqErr` in the accept cycle and leave the block idle.
- R3: A length of 0, or a length above the buffer size (256), raises `reqErr` and leaves the block idle.
- R4: The first chunk has address = start address. Its length is min(length, 64 − (start mod 64)).
- R5: Each later chunk has address = start + bytes already answered, with the low 6 bits zero. Its length is min(bytes remaining, 64).
- R6: Only one chunk is in flight. `memReqValid` holds, with a stable address, until `memReqReady`. It then drops and stays low until a matching response arrives.
- R7: `memReqLineAddr` equals `memReqAddr` with the low 6 bits cleared. `memReqWrite` is 1 for stores and 0 for loads.
- R8: When a read chunk is answered, response byte (offset + j) is stored in buffer location (bytes answered + j) for each j below the chunk length. The offset is the chunk's address mod 64. A byte k of a 512-bit data word sits at bits [8k+7:8k].
- R9: On a write chunk, buffer location (bytes answered + j) appears at line byte (offset + j) of `memReqData`. All other bytes are zero.
- R10: `done` pulses for one cycle, in the same cycle as the response that answers the last chunk.
- R11: A response of the wrong kind raises `rspErr` in that cycle and is ignored: nothing is issued and the transfer does not advance. A data response (`memRspIsData` = 1) on a write is the wrong kind, as is an acknowledgement (`memRspIsData` = 0) on a read. Any response while no chunk is outstanding is also the wrong kind.
- R12: `hostBufRdata` shows buffer location `hostBufAddr` combinationally. `hostBufWe` writes the buffer only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqReady | output | 1 | Block idle, request accepted |
| reqOp | input | 3 | Operation code (0 load, 1 store) |
| reqAddr | input | 32 | Start byte address |
| reqLen | input | 9 | Byte count |
| reqErr | output | 1 | Request rejected this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed this cycle |
| hostBufWe | input | 1 | Host buffer write strobe |
| hostBufAddr | input | 8 | Host buffer byte index |
| hostBufWdata | input | 8 | Host buffer write byte |
| hostBufRdata | output | 8 | Host buffer read byte |
| memReqValid | output | 1 | Chunk request valid |
| memReqReady | input | 1 | Memory port accepts chunk |
| memReqAddr | output | 32 | Chunk byte address |
| memReqLineAddr | output | 32 | Chunk line address |
| memReqLen | output | 7 | Chunk byte count (1 to 64) |
| memReqWrite | output | 1 | Chunk is a store |
| memReqData | output | 512 | Store data, line-positioned |
| memRspValid | input | 1 | Response present |
| memRspIsData | input | 1 | 1 data response, 0 acknowledgement |
| memRspData | input | 512 | Read line data |
| rspErr | output | 1 | Unexpected response this cycle |

## Verification
The hardest case is a wrong-kind response that lands while a chunk is outstanding. The bench must show that it is dropped without moving the byte counters. To get there, the bench starts a read transfer that spans several lines. It lets the first chunk be accepted, sends an acknowledgement instead of data, and then checks that no new chunk appears and that the correct data still lands in the right buffer locations afterwards. A host buffer write made during a store transfer is checked the same way: the data of the later chunks must still carry the preloaded bytes.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_FETCH   = 3'd2,
    OP_LOCK_RD = 3'd3,
    OP_LOCK_WR = 3'd4,
    OP_RMW_RD  = 3'd5,
    OP_RMW_WR  = 3'd6,
    OP_NONE    = 3'd7
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new transfer
    logic advance;  // chunk accepted downstream
    logic capture;  // matching response arrived
  } seqStrobe_t;

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  localparam int LEN_W = $clog2(BUF_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic             memRspIsData,
  input  logic             allIssued,
  output logic             reqReady,
  output logic             reqErr,
  output logic             busy,
  output logic             done,
  output logic             memReqValid,
  output logic             rspErr,
  output logic             isWrite,
  output seqStrobe_t       strobe
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seqState_e;

  seqState_e state, stateNext;
  logic      opOk, lenOk, accept, rspMatch;

  assign opOk     = (reqOp == OP_LOAD) || (reqOp == OP_STORE);
  assign lenOk    = (reqLen != '0) && (reqLen <= LEN_W'(BUF_BYTES));
  assign accept   = reqValid && (state == S_IDLE);
  assign rspMatch = (state == S_WAIT) && memRspValid && (memRspIsData == !isWrite);

  assign reqReady       = (state == S_IDLE);
  assign busy           = (state != S_IDLE);
  assign reqErr         = accept && !(opOk && lenOk);
  assign memReqValid    = (state == S_ISSUE);
  assign strobe.load    = accept && opOk && lenOk;
  assign strobe.advance = memReqValid && memReqReady;
  assign strobe.capture = rspMatch;
  assign done           = rspMatch && allIssued;
  assign rspErr         = memRspValid && !rspMatch;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (strobe.load) stateNext = S_ISSUE;
      S_ISSUE: if (strobe.advance) stateNext = S_WAIT;
      S_WAIT:  if (rspMatch) stateNext = allIssued ? S_IDLE : S_ISSUE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isWrite <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.load) isWrite <= (reqOp == OP_STORE);
    end
  end

  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);
  p_reject_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |=> !busy);
  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);
  p_single_flight_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);
  p_done_frees_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && reqReady);
  p_ignore_bad_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspErr && !memReqValid |=> !memReqValid);

endmodule

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int BUF_BYTES  = 256,
  localparam int LEN_W  = $clog2(BUF_BYTES) + 1,
  localparam int BUF_AW = $clog2(BUF_BYTES),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int CLEN_W = OFF_W + 1,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              isWrite,
  input  logic              reqActive,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              hostWe,
  input  logic [BUF_AW-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  input  logic [LINE_W-1:0] rspData,
  output logic [ADDR_W-1:0] chunkAddr,
  output logic [ADDR_W-1:0] chunkLineAddr,
  output logic [CLEN_W-1:0] chunkLen,
  output logic [LINE_W-1:0] chunkData,
  output logic              allIssued
);

  logic [ADDR_W-1:0] startAddr;
  logic [LEN_W-1:0]  totalLen, doneBytes, sentBytes, remaining;
  logic [OFF_W-1:0]  lineOff;
  logic [CLEN_W-1:0] room;
  logic [LINE_W-1:0] rspAligned, winData;
  logic [7:0]        bufMem [BUF_BYTES];

  assign chunkAddr     = startAddr + ADDR_W'(doneBytes);
  assign chunkLineAddr = chunkAddr & ~ADDR_W'(LINE_BYTES - 1);
  assign lineOff       = chunkAddr[OFF_W-1:0];
  assign remaining     = totalLen - doneBytes;
  assign room          = CLEN_W'(LINE_BYTES) - {1'b0, lineOff};
  assign chunkLen      = (remaining < LEN_W'(room)) ? CLEN_W'(remaining) : room;
  assign allIssued     = (sentBytes == totalLen);
  assign hostRdata     = bufMem[hostAddr];

  // read data: move the requested bytes down to byte 0
  assign rspAligned = rspData >> {lineOff, 3'b000};

  // write data: gather from buffer, then move up to the line offset
  always_comb begin
    for (int j = 0; j < LINE_BYTES; j++) begin
      winData[j*8 +: 8] = (CLEN_W'(j) < chunkLen) ?
                          bufMem[BUF_AW'(doneBytes) + BUF_AW'(j)] : 8'h00;
    end
  end
  assign chunkData = isWrite ? (winData << {lineOff, 3'b000}) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      totalLen  <= '0;
      doneBytes <= '0;
      sentBytes <= '0;
    end else begin
      if (strobe.load) begin
        startAddr <= reqAddr;
        totalLen  <= reqLen;
        doneBytes <= '0;
        sentBytes <= '0;
      end
      if (strobe.advance) sentBytes <= doneBytes + LEN_W'(chunkLen);
      if (strobe.capture) doneBytes <= sentBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (hostWe) bufMem[hostAddr] <= hostWdata;
    if (strobe.capture && !isWrite) begin
      for (int j = 0; j < LINE_BYTES; j++) begin
        if (CLEN_W'(j) < chunkLen)
          bufMem[BUF_AW'(doneBytes) + BUF_AW'(j)] <= rspAligned[j*8 +: 8];
      end
    end
  end

  p_later_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqActive && (doneBytes != '0) |-> (chunkAddr[OFF_W-1:0] == '0));
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqActive |-> (chunkLen != '0) && (LEN_W'(chunkLen) <= remaining));
  p_in_line_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqActive |-> ((chunkAddr + ADDR_W'(chunkLen) - 1) & ~ADDR_W'(LINE_BYTES - 1))
                  == chunkLineAddr);

endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int BUF_BYTES  = 256,
  localparam int LEN_W  = $clog2(BUF_BYTES) + 1,
  localparam int BUF_AW = $clog2(BUF_BYTES),
  localparam int CLEN_W = $clog2(LINE_BYTES) + 1,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              reqErr,
  output logic              busy,
  output logic              done,
  input  logic              hostBufWe,
  input  logic [BUF_AW-1:0] hostBufAddr,
  input  logic [7:0]        hostBufWdata,
  output logic [7:0]        hostBufRdata,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] memReqLineAddr,
  output logic [CLEN_W-1:0] memReqLen,
  output logic              memReqWrite,
  output logic [LINE_W-1:0] memReqData,
  input  logic              memRspValid,
  input  logic              memRspIsData,
  input  logic [LINE_W-1:0] memRspData,
  output logic              rspErr
);

  seqStrobe_t strobe;
  logic       allIssued, isWrite;

  assign memReqWrite = isWrite;

  dma_seq_ctrl #(.BUF_BYTES(BUF_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqLen(reqLen),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspIsData(memRspIsData),
    .allIssued(allIssued), .reqReady(reqReady), .reqErr(reqErr), .busy(busy),
    .done(done), .memReqValid(memReqValid), .rspErr(rspErr), .isWrite(isWrite),
    .strobe(strobe)
  );

  dma_seq_datapath #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BUF_BYTES(BUF_BYTES)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isWrite(isWrite), .reqActive(memReqValid),
    .reqAddr(reqAddr), .reqLen(reqLen), .hostWe(hostBufWe && !busy),
    .hostAddr(hostBufAddr), .hostWdata(hostBufWdata), .hostRdata(hostBufRdata),
    .rspData(memRspData), .chunkAddr(memReqAddr), .chunkLineAddr(memReqLineAddr),
    .chunkLen(memReqLen), .chunkData(memReqData), .allIssued(allIssued)
  );

  p_stable_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr) && $stable(memReqLen));
  p_line_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqLineAddr[$clog2(LINE_BYTES)-1:0] == '0)
                    && ((memReqAddr ^ memReqLineAddr) < ADDR_W'(LINE_BYTES)));

endmodule

// File: tb/sim_dma_line_seq.sv
module sim_dma_line_seq;

  localparam int LINE = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [2:0]   reqOp = 3'd0;
  logic [31:0]  reqAddr = '0;
  logic [8:0]   reqLen = '0;
  logic         reqErr, busy, done;
  logic         hostBufWe = 1'b0;
  logic [7:0]   hostBufAddr = '0;
  logic [7:0]   hostBufWdata = '0;
  logic [7:0]   hostBufRdata;
  logic         memReqValid;
  logic         memReqReady = 1'b0;
  logic [31:0]  memReqAddr, memReqLineAddr;
  logic [6:0]   memReqLen;
  logic         memReqWrite;
  logic [511:0] memReqData;
  logic         memRspValid = 1'b0;
  logic         memRspIsData = 1'b0;
  logic [511:0] memRspData = '0;
  logic         rspErr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  dma_line_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqErr(reqErr), .busy(busy), .done(done),
    .hostBufWe(hostBufWe), .hostBufAddr(hostBufAddr), .hostBufWdata(hostBufWdata),
    .hostBufRdata(hostBufRdata), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqLineAddr(memReqLineAddr), .memReqLen(memReqLen),
    .memReqWrite(memReqWrite), .memReqData(memReqData), .memRspValid(memRspValid),
    .memRspIsData(memRspIsData), .memRspData(memRspData), .rspErr(rspErr)
  );

  // {start address, length, store}
  localparam logic [41:0] VEC [7] = '{
    {32'h0000_0100, 9'd64,  1'b0},
    {32'h0000_0105, 9'd10,  1'b0},
    {32'h0000_013A, 9'd100, 1'b0},
    {32'h0000_0200, 9'd256, 1'b1},
    {32'h0000_023F, 9'd2,   1'b1},
    {32'h0000_01C0, 9'd65,  1'b0},
    {32'h0000_00FF, 9'd1,   1'b1}
  };

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] * 8'd7 + a[15:8] + 8'h03;
  endfunction

  function automatic logic [7:0] wrByte(input int i, input int job);
    return 8'(i * 3) ^ 8'(job * 17);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic runJob(input logic [31:0] a, input int n, input bit wr, input int delay,
                        input bit badRsp, input bit poke, input int job);
    int doneB = 0;
    int dataErr = 0;
    bit first = 1'b1;
    if (wr) begin
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        hostBufWe = 1'b1; hostBufAddr = 8'(i); hostBufWdata = wrByte(i, job);
      end
      @(negedge clk);
      hostBufWe = 1'b0;
    end
    @(negedge clk);
    reqValid = 1'b1; reqOp = wr ? 3'd1 : 3'd0; reqAddr = a; reqLen = 9'(n);
    #1;
    check(reqReady && !reqErr, "R1", "accept when idle", {reqReady, reqErr}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy && !reqReady, "R1", "busy after accept", {busy, reqReady}, 2'b10);
    while (doneB < n) begin
      int off  = first ? int'(a % 64) : 0;
      int clen = (n - doneB < LINE - off) ? n - doneB : LINE - off;
      logic [31:0] ea = a + 32'(doneB);
      int waitCnt = 0;
      while (!memReqValid && waitCnt < 20) begin @(negedge clk); waitCnt++; end
      check(memReqAddr == ea && memReqLen == 7'(clen), first ? "R4" : "R5",
            "chunk addr/len", {memReqAddr, 25'd0, memReqLen}, {ea, 25'd0, 7'(clen)});
      check(memReqLineAddr == (ea & ~32'h3F) && memReqWrite == wr, "R7",
            "line addr/type", {memReqLineAddr, 31'd0, memReqWrite},
            {ea & ~32'h3F, 31'd0, wr});
      if (wr) begin
        int bad = 0;
        for (int k = 0; k < LINE; k++) begin
          logic [7:0] exp = (k >= off && k < off + clen) ? wrByte(doneB + k - off, job) : 8'h00;
          if (memReqData[k*8 +: 8] != exp) bad++;
        end
        check(bad == 0, "R9", "write data bytes wrong", 64'(bad), 64'd0);
      end
      for (int d = 0; d < delay; d++) begin
        @(negedge clk);
        check(memReqValid && memReqAddr == ea, "R6", "hold while not ready",
              {memReqValid, memReqAddr}, {1'b1, ea});
      end
      memReqReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      memReqReady = 1'b0;
      check(!memReqValid, "R6", "drop after accept", memReqValid, 0);
      if (poke && first) begin
        hostBufWe = 1'b1; hostBufAddr = 8'(n - 1); hostBufWdata = ~wrByte(n - 1, job);
      end
      @(negedge clk);
      hostBufWe = 1'b0;
      check(!memReqValid, "R6", "no issue before response", memReqValid, 0);
      if (badRsp) begin
        memRspValid = 1'b1; memRspIsData = wr;
        for (int k = 0; k < LINE; k++) memRspData[k*8 +: 8] = 8'hEE;
        #1;
        check(rspErr && !done, "R11", "wrong-kind response flagged", {rspErr, done}, 2'b10);
        @(posedge clk);
        @(negedge clk);
        memRspValid = 1'b0;
        check(!memReqValid && busy, "R11", "wrong-kind response ignored",
              {memReqValid, busy}, 2'b01);
        badRsp = 1'b0;
      end
      memRspValid = 1'b1; memRspIsData = !wr;
      for (int k = 0; k < LINE; k++) memRspData[k*8 +: 8] = memByte((ea & ~32'h3F) + 32'(k));
      #1;
      check(done == (doneB + clen == n) && !rspErr, "R10", "done on last response",
            {done, rspErr}, {(doneB + clen == n), 1'b0});
      @(posedge clk);
      @(negedge clk);
      memRspValid = 1'b0;
      doneB += clen;
      first = 1'b0;
      check(busy == (doneB < n), "R1", "busy until finished", busy, (doneB < n));
    end
    if (!wr) begin
      for (int i = 0; i < n; i++) begin
        hostBufAddr = 8'(i);
        #1;
        if (hostBufRdata != memByte(a + 32'(i))) dataErr++;
      end
      check(dataErr == 0, "R8", "read bytes gathered wrongly", 64'(dataErr), 64'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !busy && !memReqValid && !done && !reqErr && !rspErr, "R1",
          "reset state", {reqReady, busy, memReqValid, done}, 4'b1000);

    for (int v = 0; v < 7; v++) begin
      runJob(VEC[v][41:10], int'(VEC[v][9:1]), VEC[v][0], v % 3, 1'b0, v == 3, v);
    end

    // R2: unsupported operation codes
    for (int op = 2; op < 8; op += 3) begin
      @(negedge clk);
      reqValid = 1'b1; reqOp = 3'(op); reqAddr = 32'h40; reqLen = 9'd8;
      #1;
      check(reqErr, "R2", "bad op flagged", reqErr, 1);
      @(posedge clk);
      @(negedge clk);
      reqValid = 1'b0;
      check(!busy && !memReqValid, "R2", "bad op stays idle", {busy, memReqValid}, 0);
    end

    // R3: zero length and oversize
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      reqValid = 1'b1; reqOp = 3'd0; reqAddr = 32'h40; reqLen = (t == 0) ? 9'd0 : 9'd257;
      #1;
      check(reqErr, "R3", "bad length flagged", reqErr, 1);
      @(posedge clk);
      @(negedge clk);
      reqValid = 1'b0;
      check(!busy, "R3", "bad length stays idle", busy, 0);
    end

    // R11: response with nothing outstanding
    @(negedge clk);
    memRspValid = 1'b1; memRspIsData = 1'b1;
    #1;
    check(rspErr && !done, "R11", "idle response flagged", {rspErr, done}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    memRspValid = 1'b0;
    check(!busy && !memReqValid, "R11", "idle response ignored", {busy, memReqValid}, 0);

    // R11: wrong-kind response mid read transfer
    runJob(32'h0000_0290, 150, 1'b0, 1, 1'b1, 1'b0, 9);
    // R11: wrong-kind response on a write
    runJob(32'h0000_0310, 70, 1'b1, 0, 1'b1, 1'b0, 10);

    // R12: host read port shows written byte while idle
    @(negedge clk);
    hostBufWe = 1'b1; hostBufAddr = 8'd200; hostBufWdata = 8'h5A;
    @(negedge clk);
    hostBufWe = 1'b0;
    #1;
    check(hostBufRdata == 8'h5A, "R12", "host write/read", hostBufRdata, 8'h5A);

    finishRun();
  end

endmodule